// File: doc/BRIEF.md
# Tile Background Pixel Generator

This block turns one screen coordinate of a 256×240 tiled background into a 4-bit colour index and the matching palette memory address. A caller raises `start` for one cycle with the pixel position, the name table to use and a one-bit pattern bank. The block then makes four reads on a synchronous video-memory port, each with a single cycle of latency. The first read fetches the tile number from the name table. The second fetches the attribute byte that covers a 4×4-tile block. The third and fourth fetch the two bit-plane bytes of the tile row that holds the pixel.

The pixel's two low colour bits come from the two plane bytes. The two high bits come from one quadrant of the attribute byte. If the low value is zero, the block reports the shared backdrop entry. Name tables sit 0x400 apart from 0x2000 upward. Patterns take 16 bytes per tile, and the bank bit adds 0x1000. The background palette starts at 0x3F00.

The coordinates, the table select and the bank are latched when `start` is accepted, so they may change while the fetch is in progress. A request raised while a fetch is running is dropped.

Top module: `bg_pixel_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pix_valid` is 0, `color_idx` is 0 and `pal_addr` is 0x3F00.
- R2: `start` is accepted on a clock edge while the block is idle. In the cycle after that edge, `vram_addr` holds the name byte address 0x2000 + nt_sel·0x400 + (y>>3)·32 + (x>>3).
- R3: In the cycle after that, `vram_addr` holds the attribute address 0x2000 + nt_sel·0x400 + 0x3C0 + (y>>5)·8 + (x>>5).
- R4: The next two cycles present the plane addresses. The low-bit plane address is bank·0x1000 + tile·16 + (y&7), where tile is the byte read from the name address. The high-bit plane address is the same value plus 8.
- R5: The quadrant is the pair ((y>>4)&1, (x>>4)&1). Quadrant (0,0) takes attribute bits 1:0, (0,1) takes bits 3:2, (1,0) takes bits 5:4 and (1,1) takes bits 7:6. The selected pair becomes `color_idx[3:2]`.
- R6: Pixel bit (7 − (x&7)) of the low plane byte gives `color_idx[0]`, and the same bit of the high plane byte gives `color_idx[1]`. The leftmost pixel uses bit 7.
- R7: When `pix_valid` is high, `pal_addr` equals 0x3F00 + `color_idx`.
- R8: When both plane bits are 0, `color_idx` is 0 and `pal_addr` is 0x3F00, whatever the attribute holds.
- R9: If `start` is accepted at edge n, `pix_valid` is high only in the cycle between edges n+5 and n+6.
- R10: `start` is ignored while a fetch is running. That request produces no extra result and does not disturb the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a pixel; accepted when idle |
| pix_x | input | 8 | Pixel column, 0..255 |
| pix_y | input | 8 | Pixel row, 0..239 |
| nt_sel | input | 2 | Name table select |
| pat_bank | input | 1 | Pattern bank bit (adds 0x1000) |
| vram_addr | output | 14 | Video memory read address (registered) |
| vram_rdata | input | 8 | Read data, valid one cycle after the address |
| pix_valid | output | 1 | One-cycle result strobe |
| color_idx | output | 4 | Background colour index |
| pal_addr | output | 14 | Palette memory address of the colour |

## Verification
The bench drives a table of coordinates spread over all four name tables, both banks, both screen corners and interior tiles. Video memory is a computed address-to-byte function, so every fetch returns a different value. This separates swapped row and column terms, a wrong attribute grid divisor and a missing bank offset. Directed cases then override the attribute and plane bytes. A 0xE4 attribute with solid planes makes each quadrant show a different high pair. Single-bit planes at columns 0 and 7 expose a reversed bit order. Empty planes under a 0xFF attribute prove that the backdrop overrides the attribute. A second request placed mid-fetch shows whether the block restarts or emits twice.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int CIDX_W = 4;
  localparam int PLANES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK_ATTR,
    ST_ASK_LO,
    ST_ASK_HI,
    ST_TAKE_LO,
    ST_EMIT
  } fetch_state_e;
endpackage

// File: rtl/bg_addr_gen.sv
// Name byte and attribute byte addresses from coarse tile coordinates.
module bg_addr_gen #(
  parameter int ADDR_W    = 14,
  parameter int CRS_W     = 5,
  parameter int NT_W      = 2,
  parameter int COLS      = 32,
  parameter int ATTR_GRP  = 4,
  parameter int NT_BASE   = 'h2000,
  parameter int NT_STRIDE = 'h400,
  parameter int ATTR_OFS  = 'h3C0
) (
  input  logic [CRS_W-1:0]  cx,
  input  logic [CRS_W-1:0]  cy,
  input  logic [NT_W-1:0]   nt,
  output logic [ADDR_W-1:0] name_addr,
  output logic [ADDR_W-1:0] attr_addr
);
  localparam int ATTR_COLS = COLS / ATTR_GRP;

  always_comb begin
    name_addr = ADDR_W'(NT_BASE + 32'(nt) * NT_STRIDE + 32'(cy) * COLS + 32'(cx));
    attr_addr = ADDR_W'(NT_BASE + 32'(nt) * NT_STRIDE + ATTR_OFS
                        + (32'(cy) / ATTR_GRP) * ATTR_COLS + 32'(cx) / ATTR_GRP);
  end
endmodule

// File: rtl/bg_pattern_addr.sv
// One address per bit-plane for the row of the selected tile.
module bg_pattern_addr #(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int FINE_W     = 3,
  parameter int TILE_PX    = 8,
  parameter int PAT_STRIDE = 16,
  parameter int PAT_BANK   = 'h1000
) (
  input  logic [DATA_W-1:0] tile,
  input  logic [FINE_W-1:0] fine_y,
  input  logic              bank,
  output logic [ADDR_W-1:0] plane_addr [bg_pkg::PLANES]
);
  for (genvar p = 0; p < bg_pkg::PLANES; p++) begin : g_plane
    assign plane_addr[p] = ADDR_W'(32'(bank) * PAT_BANK + 32'(tile) * PAT_STRIDE
                                   + 32'(fine_y) + p * TILE_PX);
  end
endmodule

// File: rtl/bg_attr_sel.sv
// Picks the two high colour bits for the 2x2-tile quadrant.
module bg_attr_sel #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] attr,
  input  logic              qx,
  input  logic              qy,
  output logic [1:0]        hi_bits
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = attr >> {qy, qx, 1'b0};
    hi_bits = shifted[1:0];
  end
endmodule

// File: rtl/bg_pixel_mux.sv
// Combines plane bits and attribute bits into a colour and palette address.
module bg_pixel_mux #(
  parameter int ADDR_W   = 14,
  parameter int TILE_PX  = 8,
  parameter int FINE_W   = 3,
  parameter int PAL_BASE = 'h3F00
) (
  input  logic [bg_pkg::PLANES-1:0][TILE_PX-1:0] planes,
  input  logic [FINE_W-1:0]                      fine_x,
  input  logic [1:0]                             hi_bits,
  output logic [bg_pkg::CIDX_W-1:0]              color,
  output logic [ADDR_W-1:0]                      pal
);
  logic [bg_pkg::PLANES-1:0] low;
  logic [FINE_W-1:0]         bit_pos;

  assign bit_pos = FINE_W'(TILE_PX - 1) - fine_x;

  for (genvar p = 0; p < bg_pkg::PLANES; p++) begin : g_bit
    assign low[p] = planes[p][bit_pos];
  end

  always_comb begin
    color = (low == '0) ? '0 : {hi_bits, low};
    pal   = ADDR_W'(PAL_BASE + 32'(color));
  end
endmodule

// File: rtl/bg_pixel_gen.sv
module bg_pixel_gen #(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int PIX_W      = 8,
  parameter int NT_W       = 2,
  parameter int TILE_PX    = 8,
  parameter int COLS       = 32,
  parameter int ATTR_GRP   = 4,
  parameter int NT_BASE    = 'h2000,
  parameter int NT_STRIDE  = 'h400,
  parameter int ATTR_OFS   = 'h3C0,
  parameter int PAT_STRIDE = 16,
  parameter int PAT_BANK   = 'h1000,
  parameter int PAL_BASE   = 'h3F00
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [PIX_W-1:0]          pix_x,
  input  logic [PIX_W-1:0]          pix_y,
  input  logic [NT_W-1:0]           nt_sel,
  input  logic                      pat_bank,
  output logic [ADDR_W-1:0]         vram_addr,
  input  logic [DATA_W-1:0]         vram_rdata,
  output logic                      pix_valid,
  output logic [bg_pkg::CIDX_W-1:0] color_idx,
  output logic [ADDR_W-1:0]         pal_addr
);
  import bg_pkg::*;

  localparam int FINE_W = $clog2(TILE_PX);
  localparam int CRS_W  = PIX_W - FINE_W;
  localparam int QB     = FINE_W + $clog2(ATTR_GRP) - 1;

  fetch_state_e      state;
  logic [PIX_W-1:0]  x_q, y_q;
  logic [NT_W-1:0]   nt_q;
  logic              bank_q;
  logic [DATA_W-1:0] tile_q, attr_q, lo_q;

  logic [PIX_W-1:0]  x_use, y_use;
  logic [NT_W-1:0]   nt_use;
  logic [DATA_W-1:0] tile_use;
  logic [ADDR_W-1:0] name_addr, attr_addr;
  logic [ADDR_W-1:0] plane_addr [PLANES];
  logic [1:0]        hi_bits;
  logic [CIDX_W-1:0] color_nx;
  logic [ADDR_W-1:0] pal_nx;

  // The name address is issued on the accepting edge, from the live inputs.
  always_comb begin
    x_use    = (state == ST_IDLE) ? pix_x  : x_q;
    y_use    = (state == ST_IDLE) ? pix_y  : y_q;
    nt_use   = (state == ST_IDLE) ? nt_sel : nt_q;
    // The tile number arrives on the read port in ST_ASK_LO.
    tile_use = (state == ST_ASK_LO) ? vram_rdata : tile_q;
  end

  bg_addr_gen #(
    .ADDR_W(ADDR_W), .CRS_W(CRS_W), .NT_W(NT_W), .COLS(COLS),
    .ATTR_GRP(ATTR_GRP), .NT_BASE(NT_BASE), .NT_STRIDE(NT_STRIDE), .ATTR_OFS(ATTR_OFS)
  ) u_addr (
    .cx(x_use[PIX_W-1:FINE_W]),
    .cy(y_use[PIX_W-1:FINE_W]),
    .nt(nt_use),
    .name_addr(name_addr),
    .attr_addr(attr_addr)
  );

  bg_pattern_addr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FINE_W(FINE_W), .TILE_PX(TILE_PX),
    .PAT_STRIDE(PAT_STRIDE), .PAT_BANK(PAT_BANK)
  ) u_pat (
    .tile(tile_use),
    .fine_y(y_q[FINE_W-1:0]),
    .bank(bank_q),
    .plane_addr(plane_addr)
  );

  bg_attr_sel #(.DATA_W(DATA_W)) u_attr (
    .attr(attr_q),
    .qx(x_q[QB]),
    .qy(y_q[QB]),
    .hi_bits(hi_bits)
  );

  // The high plane byte is used straight from the read port in ST_EMIT.
  bg_pixel_mux #(
    .ADDR_W(ADDR_W), .TILE_PX(TILE_PX), .FINE_W(FINE_W), .PAL_BASE(PAL_BASE)
  ) u_mux (
    .planes({vram_rdata, lo_q}),
    .fine_x(x_q[FINE_W-1:0]),
    .hi_bits(hi_bits),
    .color(color_nx),
    .pal(pal_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      x_q       <= '0;
      y_q       <= '0;
      nt_q      <= '0;
      bank_q    <= 1'b0;
      tile_q    <= '0;
      attr_q    <= '0;
      lo_q      <= '0;
      vram_addr <= '0;
      pix_valid <= 1'b0;
      color_idx <= '0;
      pal_addr  <= ADDR_W'(PAL_BASE);
    end else begin
      pix_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            x_q       <= pix_x;
            y_q       <= pix_y;
            nt_q      <= nt_sel;
            bank_q    <= pat_bank;
            vram_addr <= name_addr;
            state     <= ST_ASK_ATTR;
          end
        end
        ST_ASK_ATTR: begin
          vram_addr <= attr_addr;
          state     <= ST_ASK_LO;
        end
        ST_ASK_LO: begin
          tile_q    <= vram_rdata;
          vram_addr <= plane_addr[0];
          state     <= ST_ASK_HI;
        end
        ST_ASK_HI: begin
          attr_q    <= vram_rdata;
          vram_addr <= plane_addr[1];
          state     <= ST_TAKE_LO;
        end
        ST_TAKE_LO: begin
          lo_q  <= vram_rdata;
          state <= ST_EMIT;
        end
        ST_EMIT: begin
          color_idx <= color_nx;
          pal_addr  <= pal_nx;
          pix_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bg_pixel_gen_chk.sv
module bg_pixel_gen_chk #(
  parameter int ADDR_W   = 14,
  parameter int PAL_BASE = 'h3F00
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start,
  input logic                      pix_valid,
  input logic [bg_pkg::CIDX_W-1:0] color_idx,
  input logic [ADDR_W-1:0]         pal_addr
);
  // R9: the result strobe lasts a single cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);

  // R9: a result follows a request by a fixed latency
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(start, 6));

  // R7: the palette address tracks the colour index
  a_r7_pal_map: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (pal_addr == ADDR_W'(PAL_BASE) + ADDR_W'(color_idx)));

  // R8: a transparent pixel reports the backdrop entry
  a_r8_backdrop: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && color_idx[1:0] == 2'b00) |-> (color_idx == '0));

  // R10: no two results closer than the fetch length
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> !$past(pix_valid, 2));
endmodule

bind bg_pixel_gen bg_pixel_gen_chk #(.ADDR_W(ADDR_W), .PAL_BASE(PAL_BASE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .pix_valid(pix_valid),
  .color_idx(color_idx), .pal_addr(pal_addr)
);

// File: tb/bg_pixel_gen_test.sv
module bg_pixel_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {x, y, nt, bank}
  localparam logic [18:0] STIM [NVEC] = '{
    {8'd0,   8'd0,   2'd0, 1'b0},
    {8'd255, 8'd239, 2'd3, 1'b1},
    {8'd17,  8'd42,  2'd1, 1'b0},
    {8'd100, 8'd200, 2'd2, 1'b1},
    {8'd64,  8'd128, 2'd0, 1'b1},
    {8'd9,   8'd231, 2'd1, 1'b1},
    {8'd200, 8'd15,  2'd3, 1'b0},
    {8'd127, 8'd127, 2'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  pix_x = '0, pix_y = '0;
  logic [1:0]  nt_sel = '0;
  logic        pat_bank = 1'b0;
  logic [13:0] vram_addr;
  logic [7:0]  vram_rdata = '0;
  logic        pix_valid;
  logic [3:0]  color_idx;
  logic [13:0] pal_addr;

  int checks = 0;
  int errors = 0;

  logic [13:0] ovr_a [3];
  logic [7:0]  ovr_d [3];
  logic        ovr_en [3] = '{1'b0, 1'b0, 1'b0};

  int e_nt, e_at, e_p0, e_p1, e_col, e_pal;

  bg_pixel_gen uut (
    .clk(clk), .rst(rst), .start(start), .pix_x(pix_x), .pix_y(pix_y),
    .nt_sel(nt_sel), .pat_bank(pat_bank), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .pix_valid(pix_valid), .color_idx(color_idx),
    .pal_addr(pal_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] mem_rd(input logic [13:0] a);
    logic [31:0] t;
    for (int i = 0; i < 3; i++)
      if (ovr_en[i] && ovr_a[i] == a) return ovr_d[i];
    t = 32'(a) * 37 + (32'(a) >> 5) * 11 + 32'h5A;
    return t[7:0];
  endfunction

  always @(posedge clk) vram_rdata <= mem_rd(vram_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model(input int x, input int y, input int nt, input int bk);
    int cx, cy, base, tile, q, hi, b0, b1, lo;
    cx = x >> 3; cy = y >> 3;
    base = 'h2000 + nt * 'h400;
    e_nt = base + cy * 32 + cx;
    e_at = base + 'h3C0 + (cy >> 2) * 8 + (cx >> 2);
    tile = int'(mem_rd(14'(e_nt)));
    e_p0 = bk * 'h1000 + tile * 16 + (y & 7);
    e_p1 = e_p0 + 8;
    q  = ((cy >> 1) & 1) * 2 + ((cx >> 1) & 1);
    hi = (int'(mem_rd(14'(e_at))) >> (2 * q)) & 3;
    b0 = (int'(mem_rd(14'(e_p0))) >> (7 - (x & 7))) & 1;
    b1 = (int'(mem_rd(14'(e_p1))) >> (7 - (x & 7))) & 1;
    lo = b1 * 2 + b0;
    e_col = (lo == 0) ? 0 : hi * 4 + lo;
    e_pal = 'h3F00 + e_col;
  endtask

  task automatic run_pixel(input int x, input int y, input int nt, input int bk,
                           input int lit_col, input bit poke, input string tag);
    int vcount, vfirst, got_col, got_pal;
    model(x, y, nt, bk);
    vcount = 0; vfirst = 0; got_col = -1; got_pal = -1;
    @(negedge clk);
    pix_x = 8'(x); pix_y = 8'(y); nt_sel = 2'(nt); pat_bank = bk[0]; start = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        pix_x = ~8'(x); pix_y = 8'(x + y); nt_sel = 2'(nt + 1); pat_bank = ~pat_bank;
      end
      if (poke && k == 2) begin start = 1'b1; pix_x = 8'(x + 77); end
      if (poke && k == 3) start = 1'b0;
      if (k == 1) chk(vram_addr == 14'(e_nt), "R2 name addr", int'(vram_addr), e_nt);
      if (k == 2) chk(vram_addr == 14'(e_at), "R3 attr addr", int'(vram_addr), e_at);
      if (k == 3) chk(vram_addr == 14'(e_p0), "R4 plane0 addr", int'(vram_addr), e_p0);
      if (k == 4) chk(vram_addr == 14'(e_p1), "R4 plane1 addr", int'(vram_addr), e_p1);
      if (pix_valid) begin
        vcount++;
        if (vfirst == 0) begin
          vfirst = k; got_col = int'(color_idx); got_pal = int'(pal_addr);
        end
      end
    end
    chk(vfirst == 6, "R9 latency", vfirst, 6);
    chk(vcount == 1, poke ? "R10 single result" : "R9 single pulse", vcount, 1);
    chk(got_col == e_col, {tag, " colour"}, got_col, e_col);
    chk(got_pal == e_pal, "R7 palette addr", got_pal, e_pal);
    if (lit_col >= 0) chk(got_col == lit_col, {tag, " literal colour"}, got_col, lit_col);
  endtask

  task automatic directed(input int x, input int y, input int at_d, input int p0_d,
                          input int p1_d, input int lit_col, input string tag);
    for (int i = 0; i < 3; i++) ovr_en[i] = 1'b0;
    model(x, y, 0, 0);
    ovr_a[0] = 14'(e_at); ovr_d[0] = 8'(at_d);
    ovr_a[1] = 14'(e_p0); ovr_d[1] = 8'(p0_d);
    ovr_a[2] = 14'(e_p1); ovr_d[2] = 8'(p1_d);
    for (int i = 0; i < 3; i++) ovr_en[i] = 1'b1;
    run_pixel(x, y, 0, 0, lit_col, 1'b0, tag);
    for (int i = 0; i < 3; i++) ovr_en[i] = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state, during and right after reset
    chk(pix_valid == 1'b0, "R1 valid in reset", int'(pix_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid", int'(pix_valid), 0);
    chk(color_idx == 4'd0, "R1 colour", int'(color_idx), 0);
    chk(pal_addr == 14'h3F00, "R1 palette", int'(pal_addr), 'h3F00);

    // Table walk: R2, R3, R4, R7, R9 across tables, banks and corners
    for (int v = 0; v < NVEC; v++)
      run_pixel(int'(STIM[v][18:11]), int'(STIM[v][10:3]), int'(STIM[v][2:1]),
                int'(STIM[v][0]), -1, 1'b0, "R7");

    // R5: attribute 0xE4 gives quadrant number as high pair; solid planes
    for (int q = 0; q < 4; q++)
      directed((q & 1) * 16 + 3, (q >> 1) * 16 + 5, 'hE4, 'hFF, 'hFF, q * 4 + 3, "R5");

    // R6: bit order inside the plane bytes
    directed(32, 8, 'h00, 'h80, 'h00, 1, "R6 left plane0");
    directed(39, 8, 'h00, 'h01, 'h01, 3, "R6 right both");
    directed(39, 8, 'h00, 'h00, 'h01, 2, "R6 right plane1");
    directed(39, 8, 'h00, 'h80, 'h80, 0, "R6 right empty");

    // R8: empty planes force backdrop despite a full attribute
    directed(80, 96, 'hFF, 'h00, 'h00, 0, "R8");

    // R10: second request during a fetch is dropped
    run_pixel(150, 60, 1, 1, -1, 1'b1, "R10");

    summary();
    $finish;
  end
endmodule